// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer that a processor programs through five 16-bit registers. Once software enables it, a down-counter steps once per half-second tick from a programmed timeout. Software keeps the system alive only by writing a fixed two-word key to the service register in the right order. If the counter runs out, the block either pulses the internal chip reset request or drives the active-low external reset pin and holds it there. A control bit picks which of the two.

A pre-timeout interrupt can be set to warn software a chosen number of half-seconds before expiry. Software can also force a reset directly. A low-power input can freeze the count when software allows it. A power-down counter starts at reset and pulses the external line low for one clock unless software turns it off. A reset-cause flag sits in a separate power-on reset domain, so it survives the chip reset that the watchdog itself causes.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, the control register (offset 0x0) reads 0x0030, the interrupt register (0x6) reads 0x0004, the miscellaneous register (0x8) reads 0x0001, and the reset-cause register (0x4) reads 0x0000. chip_rst_o is 0, ext_rst_n_o is 1 and irq_o is 0.
- R2: Control bits 15:8 hold n. With control bit 2 set, the counter expires on the (n+1)-th tick that it counts after it was started or reloaded.
- R3: Control bit 2 (enable) is sticky. A later write of 0 to it has no effect, and the register still reads it as 1.
- R4: Control bit 0 freezes counting while lowpwr_i is high. Only the first control write after reset can change bit 0.
- R5: Writing 0x5555 and then 0xAAAA to the service register (0x2), as two consecutive service writes, reloads the counter. Any other service write returns the sequence to idle, except 0x5555, which re-arms it. Neither the reverse order nor an interrupted sequence reloads.
- R6: Control bit 3 selects the expiry action. When bit 3 is 0, expiry gives a one-cycle chip_rst_o pulse. When bit 3 is 1, expiry drives ext_rst_n_o low and holds it low until rst_n.
- R7: A control write with bit 4 at 0 gives a one-cycle chip_rst_o pulse in the following cycle. Bit 4 always reads 1.
- R8: While control bit 5 holds 0, ext_rst_n_o is low.
- R9: Reset-cause bit 1 is set by any expiry and cleared by a software reset. It is kept through rst_n and cleared only by por_n.
- R10: Interrupt register bit 15 enables the pre-timeout interrupt, and bits 7:0 give a lead L (L ≠ 0). Status bit 14 sets when a counted tick leaves L ticks before expiry, and irq_o equals bit 15 AND bit 14. Writing 1 to bit 14 clears the status; writing 0 leaves it.
- R11: While miscellaneous bit 0 is 1, ext_rst_n_o goes low for exactly one cycle on the PD_TICKS-th tick after reset. Writing 0 to bit 0 disables this for good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low chip reset |
| por_n | input | 1 | Active-low power-on reset for the reset-cause flag |
| tick_i | input | 1 | One-cycle pulse every half second |
| lowpwr_i | input | 1 | Low-power mode indication |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register byte offset |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i (combinational) |
| chip_rst_o | output | 1 | Internal reset request pulse |
| ext_rst_n_o | output | 1 | Active-low external reset line |
| irq_o | output | 1 | Pre-timeout interrupt |

## Verification
The assertions assume that tick_i is a single-cycle pulse and that a register write never lands in the same cycle as a tick. Under that assumption, each load, reload and expiry is attributed to exactly one clock edge. The bench drives every tick and every write as its own task, each occupying a separate clock cycle, so the two never overlap. lowpwr_i changes only between ticks.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam logic [3:0]  A_CTRL = 4'h0;
  localparam logic [3:0]  A_SVC  = 4'h2;
  localparam logic [3:0]  A_CAUS = 4'h4;
  localparam logic [3:0]  A_INTR = 4'h6;
  localparam logic [3:0]  A_MISC = 4'h8;
  localparam logic [15:0] KEY_A  = 16'h5555;
  localparam logic [15:0] KEY_B  = 16'hAAAA;

  typedef enum logic { K_IDLE = 1'b0, K_ARMED = 1'b1 } key_st_e;

  // number of counted ticks for a timeout code
  function automatic logic [8:0] ticks_for(input logic [7:0] n);
    return {1'b0, n} + 9'd1;
  endfunction

  function automatic logic [15:0] pack_ctrl(input logic [7:0] n, input logic ext_b,
                                            input logic act, input logic en, input logic sus);
    return {n, 2'b00, ext_b, 1'b1, act, en, 1'b0, sus};
  endfunction
endpackage

// File: rtl/kwd_keyseq.sv
module kwd_keyseq
  import kwd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        svc_wr,
  input  logic [15:0] svc_data,
  output logic        reload
);
  key_st_e st;

  assign reload = svc_wr && (st == K_ARMED) && (svc_data == KEY_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= K_IDLE;
    else if (svc_wr) st <= (svc_data == KEY_A) ? K_ARMED : K_IDLE;
  end

  // R5: a completed key always returns the sequence to idle
  p_key_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> st == K_IDLE);
endmodule

// File: rtl/kwd_countdown.sv
module kwd_countdown #(
  parameter int CW = 9,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          step,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [LW-1:0] lead,
  output logic          expire,
  output logic          pre_hit
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] nxt;

  assign nxt     = cnt - CW'(1);
  assign expire  = run && step && !load && (cnt == CW'(1));
  assign pre_hit = run && step && !load && (lead != '0) && (nxt == CW'(lead));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (load || expire)  cnt <= load_val;
    else if (run && step)     cnt <= nxt;
  end

  // R2: a load places exactly the requested tick count
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val));
  // R2: a running counter never sits at zero
  p_no_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> cnt != '0);
endmodule

// File: rtl/kwd_pdown.sv
module kwd_pdown #(
  parameter int PD_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  output logic pulse
);
  localparam int PW = (PD_TICKS > 1) ? $clog2(PD_TICKS) : 1;
  logic [PW-1:0] cnt;
  logic          done;
  logic          fire;

  assign fire = active && !done && tick && (cnt == PW'(PD_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; done <= 1'b0; pulse <= 1'b0;
    end else begin
      pulse <= fire;
      if (fire) done <= 1'b1;
      else if (active && !done && tick) cnt <= cnt + PW'(1);
    end
  end

  // R11: the power-down pulse lasts one cycle
  p_pd_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import kwd_pkg::*;
#(
  parameter int PD_TICKS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_n,
  input  logic        tick_i,
  input  logic        lowpwr_i,
  input  logic        bus_we_i,
  input  logic [3:0]  bus_addr_i,
  input  logic [15:0] bus_wdata_i,
  output logic [15:0] bus_rdata_o,
  output logic        chip_rst_o,
  output logic        ext_rst_n_o,
  output logic        irq_o
);
  localparam int CW = 9;
  localparam int LW = 8;

  logic [7:0]    tmo_n;
  logic          ext_bit, act_ext, wd_en, sus_en, sus_lock;
  logic          irq_en, irq_st, pd_en;
  logic [LW-1:0] irq_lead;
  logic          ext_latch, chip_q, cause_tout;

  logic ctrl_wr, svc_wr, intr_wr, misc_wr;
  logic start_evt, swrst_evt, reload_evt, expire_evt, pre_evt, pd_pulse;
  logic step;
  logic [CW-1:0] load_val;

  assign ctrl_wr   = bus_we_i && (bus_addr_i == A_CTRL);
  assign svc_wr    = bus_we_i && (bus_addr_i == A_SVC);
  assign intr_wr   = bus_we_i && (bus_addr_i == A_INTR);
  assign misc_wr   = bus_we_i && (bus_addr_i == A_MISC);
  assign start_evt = ctrl_wr && bus_wdata_i[2] && !wd_en;
  assign swrst_evt = ctrl_wr && !bus_wdata_i[4];
  assign step      = tick_i && !(sus_en && lowpwr_i);
  assign load_val  = start_evt ? ticks_for(bus_wdata_i[15:8]) : ticks_for(tmo_n);

  kwd_keyseq u_key (
    .clk(clk), .rst_n(rst_n), .svc_wr(svc_wr), .svc_data(bus_wdata_i), .reload(reload_evt)
  );

  kwd_countdown #(.CW(CW), .LW(LW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(wd_en), .step(step),
    .load(start_evt || (reload_evt && wd_en)), .load_val(load_val),
    .lead(irq_lead), .expire(expire_evt), .pre_hit(pre_evt)
  );

  kwd_pdown #(.PD_TICKS(PD_TICKS)) u_pd (
    .clk(clk), .rst_n(rst_n), .active(pd_en), .tick(tick_i), .pulse(pd_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_n <= '0; ext_bit <= 1'b1; act_ext <= 1'b0; wd_en <= 1'b0;
      sus_en <= 1'b0; sus_lock <= 1'b0;
      irq_en <= 1'b0; irq_st <= 1'b0; irq_lead <= LW'(4); pd_en <= 1'b1;
      ext_latch <= 1'b0; chip_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        tmo_n   <= bus_wdata_i[15:8];
        ext_bit <= bus_wdata_i[5];
        act_ext <= bus_wdata_i[3];
        wd_en   <= wd_en | bus_wdata_i[2];
        if (!sus_lock) begin
          sus_en   <= bus_wdata_i[0];
          sus_lock <= 1'b1;
        end
      end
      if (intr_wr) begin
        irq_en   <= bus_wdata_i[15];
        irq_lead <= bus_wdata_i[LW-1:0];
      end
      if (pre_evt && irq_en)              irq_st <= 1'b1;
      else if (intr_wr && bus_wdata_i[14]) irq_st <= 1'b0;
      if (misc_wr && !bus_wdata_i[0]) pd_en <= 1'b0;
      if (expire_evt && act_ext) ext_latch <= 1'b1;
      chip_q <= (expire_evt && !act_ext) || swrst_evt;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          cause_tout <= 1'b0;
    else if (expire_evt) cause_tout <= 1'b1;
    else if (swrst_evt)  cause_tout <= 1'b0;
  end

  always_comb begin
    unique case (bus_addr_i)
      A_CTRL:  bus_rdata_o = pack_ctrl(tmo_n, ext_bit, act_ext, wd_en, sus_en);
      A_CAUS:  bus_rdata_o = {14'b0, cause_tout, 1'b0};
      A_INTR:  bus_rdata_o = {irq_en, irq_st, 6'b0, irq_lead};
      A_MISC:  bus_rdata_o = {15'b0, pd_en};
      default: bus_rdata_o = '0;
    endcase
  end

  assign chip_rst_o  = chip_q;
  assign ext_rst_n_o = ext_bit && !ext_latch && !pd_pulse;
  assign irq_o       = irq_en && irq_st;

  // R3: enable never falls once set
  p_en_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wd_en) |-> wd_en);
  // R4: suspend bit frozen after the first control write
  p_sus_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sus_lock |=> $stable(sus_en));
  // R6: internal action expiry yields chip reset pulse
  p_int_act_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && !act_ext) |=> chip_rst_o);
  // R6: external action expiry holds the pin low
  p_ext_act_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && act_ext) |=> !ext_rst_n_o);
  // R7: software reset request reaches the output
  p_swrst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_evt |=> chip_rst_o);
  // R10: pre-timeout with interrupt enabled raises irq
  p_pre_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_evt && irq_en && !intr_wr) |=> irq_o);
endmodule

// File: tb/keyed_wdog_tb.sv
module keyed_wdog_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        lowpwr_i = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [3:0]  bus_addr_i = '0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic        chip_rst_o, ext_rst_n_o, irq_o;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_wdog #(.PD_TICKS(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick_i(tick_i), .lowpwr_i(lowpwr_i),
    .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .chip_rst_o(chip_rst_o), .ext_rst_n_o(ext_rst_n_o),
    .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr_i = a; #1; d = bus_rdata_o;
  endtask

  task automatic tick();
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_reset(input bit kill_pd);
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    if (kill_pd) wr(4'h8, 16'h0000);
  endtask

  task automatic t_reset_values();
    logic [15:0] v;
    rd(4'h0, v); chk("R1 ctrl", v, 16'h0030);
    rd(4'h6, v); chk("R1 intr", v, 16'h0004);
    rd(4'h8, v); chk("R1 misc", v, 16'h0001);
    rd(4'h4, v); chk("R1 cause", v, 16'h0000);
    chk("R1 outs", {13'b0, chip_rst_o, ext_rst_n_o, irq_o}, 16'h0002);
  endtask

  task automatic t_timeout_internal();
    logic [15:0] v;
    do_reset(1);
    wr(4'h0, 16'h0234);
    ticks(2);
    chk("R2 no expiry before n+1", {15'b0, chip_rst_o}, 16'h0);
    tick();
    chk("R2 R6 chip reset on tick n+1", {15'b0, chip_rst_o}, 16'h1);
    @(negedge clk);
    chk("R6 chip reset one cycle", {15'b0, chip_rst_o}, 16'h0);
    wr(4'h0, 16'h0230);
    rd(4'h0, v); chk("R3 enable sticky", v, 16'h0234);
    do_reset(1);
    rd(4'h4, v); chk("R9 cause kept through rst_n", v, 16'h0002);
    rd(4'h0, v); chk("R1 ctrl after rst_n", v, 16'h0030);
  endtask

  task automatic t_swreset();
    logic [15:0] v;
    wr(4'h0, 16'h0020);
    chk("R7 sw reset pulse", {15'b0, chip_rst_o}, 16'h1);
    rd(4'h4, v); chk("R9 cause cleared by sw reset", v, 16'h0000);
    rd(4'h0, v); chk("R7 bit4 reads 1", v & 16'h0010, 16'h0010);
  endtask

  task automatic t_key_good();
    do_reset(1);
    wr(4'h0, 16'h0334);
    ticks(3);
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    ticks(3);
    chk("R5 key reload delays expiry", {15'b0, chip_rst_o}, 16'h0);
    tick();
    chk("R5 expiry after reload", {15'b0, chip_rst_o}, 16'h1);
  endtask

  task automatic t_key_bad(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
                           input string tag);
    do_reset(1);
    wr(4'h0, 16'h0334);
    ticks(3);
    wr(4'h2, a); wr(4'h2, b); wr(4'h2, c);
    tick();
    chk(tag, {15'b0, chip_rst_o}, 16'h1);
  endtask

  task automatic t_key_double();
    do_reset(1);
    wr(4'h0, 16'h0334);
    ticks(3);
    wr(4'h2, 16'h5555); wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    tick();
    chk("R5 repeated first key re-arms", {15'b0, chip_rst_o}, 16'h0);
  endtask

  task automatic t_external();
    logic [15:0] v;
    do_reset(1);
    wr(4'h0, 16'h013C);
    tick();
    chk("R6 ext idle before expiry", {15'b0, ext_rst_n_o}, 16'h1);
    tick();
    chk("R6 ext pin low on expiry", {14'b0, ext_rst_n_o, chip_rst_o}, 16'h0);
    ticks(2);
    chk("R6 ext pin held", {15'b0, ext_rst_n_o}, 16'h0);
    rd(4'h4, v); chk("R9 cause set by ext expiry", v, 16'h0002);
    do_reset(1);
    chk("R6 ext released by rst_n", {15'b0, ext_rst_n_o}, 16'h1);
  endtask

  task automatic t_manual_ext();
    do_reset(1);
    wr(4'h0, 16'h0010);
    chk("R8 bit5 low drives pin", {15'b0, ext_rst_n_o}, 16'h0);
    wr(4'h0, 16'h0030);
    chk("R8 bit5 high releases pin", {15'b0, ext_rst_n_o}, 16'h1);
  endtask

  task automatic t_suspend();
    logic [15:0] v;
    do_reset(1);
    wr(4'h0, 16'h0335);
    lowpwr_i = 1'b1;
    ticks(10);
    chk("R4 frozen in low power", {15'b0, chip_rst_o}, 16'h0);
    lowpwr_i = 1'b0;
    wr(4'h0, 16'h0334);
    rd(4'h0, v); chk("R4 suspend bit write-once", v, 16'h0335);
    ticks(3);
    chk("R4 counting resumes", {15'b0, chip_rst_o}, 16'h0);
    tick();
    chk("R4 R2 expiry after resume", {15'b0, chip_rst_o}, 16'h1);
  endtask

  task automatic t_pretimeout();
    logic [15:0] v;
    do_reset(1);
    wr(4'h6, 16'h8002);
    wr(4'h0, 16'h0434);
    ticks(2);
    chk("R10 irq quiet early", {15'b0, irq_o}, 16'h0);
    tick();
    chk("R10 irq at lead", {15'b0, irq_o}, 16'h1);
    rd(4'h6, v); chk("R10 status bit", v, 16'hC002);
    wr(4'h6, 16'h8002);
    chk("R10 write 0 keeps status", {15'b0, irq_o}, 16'h1);
    wr(4'h6, 16'hC002);
    chk("R10 w1c clears", {15'b0, irq_o}, 16'h0);
    rd(4'h6, v); chk("R10 readback after clear", v, 16'h8002);
  endtask

  task automatic t_powerdown();
    do_reset(0);
    ticks(15);
    chk("R11 no pulse before limit", {15'b0, ext_rst_n_o}, 16'h1);
    tick();
    chk("R11 pulse at limit", {15'b0, ext_rst_n_o}, 16'h0);
    @(negedge clk);
    chk("R11 pulse single cycle", {15'b0, ext_rst_n_o}, 16'h1);
    do_reset(1);
    ticks(20);
    chk("R11 disabled by misc write", {15'b0, ext_rst_n_o}, 16'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    t_reset_values();
    t_timeout_internal();
    t_swreset();
    t_key_good();
    t_key_bad(16'hAAAA, 16'h5555, 16'h0000, "R5 reversed order no reload");
    t_key_bad(16'h5555, 16'h1234, 16'hAAAA, "R5 interrupted key no reload");
    t_key_double();
    t_external();
    t_manual_ext();
    t_suspend();
    t_pretimeout();
    t_powerdown();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule